// File: doc/BRIEF.md
# AV byte-stream packet ingress timestamper

This block sits between a codec's 8-bit byte output and the shared AV packet buffer. Each source packet opens with a one-cycle start strobe that arrives together with its first byte. The block packs the bytes into 32-bit quadlets and writes them into the buffer through a single write port. When stamping is switched on, the block takes the cycle-time value present on the start cycle and writes it as one extra quadlet in the slot just ahead of the packet's data. The stamp can be switched off for formats that carry no timestamps.

The packet length is fixed by a parameter and must be at least two bytes. A packet counts as complete when its last byte has been written. The block then moves its committed pointer past the packet's record and pulses a done flag. The buffer's consumer returns space through a read pointer. If a write finds the buffer full, the packet in progress is dropped and the write position falls back to the last committed boundary. An early start strobe and a switch to receive mode also drop the packet in progress in the same way. A start strobe raised without the valid strobe is reported and otherwise ignored. Because the path is half-duplex, nothing is written while the block is in receive mode.

Top module: `av_ingress_stamper`

## Requirements
- R1: After reset, wr_en, pkt_done, sync_err and ovf_flag are 0 and commit_ptr is 0.
- R2: Data bytes are packed big-endian. Byte k of a packet (counting from 0) goes to bits [31-8*(k mod 4) -: 8] of the packet's data quadlet k div 4.
- R3: When the packet's last byte is accepted, the final quadlet is written with its unused low bytes at zero. In that same cycle pkt_done pulses and commit_ptr moves to the slot after the final quadlet.
- R4: With stamp_en high, a start strobe writes {zeros, cycle_time} at the committed slot. The data quadlets follow at the next slots.
- R5: With stamp_en low, no stamp is written, and the first data quadlet goes to the committed slot.
- R6: If pkt_sync is high while byte_valid is low, sync_err pulses one cycle later. Nothing is written and the packet in progress is left unchanged.
- R7: Valid bytes that arrive before any start strobe, or after a packet is complete and before the next strobe, cause no write.
- R8: While rx_mode is high, nothing is written. A packet in progress is dropped and the next packet starts at the committed slot.
- R9: If a write is due while the slots used (write position minus rd_ptr) equal the buffer depth, the write is suppressed. The packet is then dropped without a done pulse, and ovf_flag rises and stays high until reset.
- R10: A start strobe that arrives before the current packet is complete drops that packet. The new packet's record begins at the committed slot.
- R11: Pointers are AW+1 bits wide and wr_addr is the pointer modulo 2^AW, so records wrap around the end of the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Codec byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_valid | input | 1 | Byte on byte_data is valid |
| pkt_sync | input | 1 | Start-of-packet strobe, coincides with the first byte |
| byte_data | input | 8 | Codec byte |
| stamp_en | input | 1 | Write a cycle-time stamp ahead of each packet |
| rx_mode | input | 1 | Layer set to receive; ingress writes blocked |
| cycle_time | input | TS_W | Current cycle-time value (count and offset) |
| rd_ptr | input | AW+1 | Consumer read pointer with wrap bit |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | AW | Buffer write address |
| wr_data | output | 32 | Buffer write quadlet |
| pkt_done | output | 1 | One-cycle pulse when a packet is committed |
| commit_ptr | output | AW+1 | Slot after the last committed record |
| sync_err | output | 1 | One-cycle pulse for a start strobe without valid |
| ovf_flag | output | 1 | Sticky buffer-overflow flag |

## Verification
A write position that has drifted would show up at wr_addr on the very next buffer write. It would also show on commit_ptr when the packet closes, which happens at most one packet length later. A lane counter that slips puts bytes into the wrong field of wr_data within four accepted bytes, and it also moves the done pulse away from the expected cycle. A rollback that fails after an overflow, an early strobe or receive mode is seen on the first stamp or data write of the following packet.

// File: rtl/av_ing_pkg.sv
package av_ing_pkg;

  // Place one byte into lane 0..3 of a quadlet, lane 0 being bits 31:24.
  function automatic logic [31:0] lane_insert(input logic [31:0] w,
                                              input logic [7:0]  b,
                                              input logic [1:0]  lane);
    logic [4:0] sh;
    sh = {2'd3 - lane, 3'b000};
    return w | ({24'd0, b} << sh);
  endfunction

endpackage

// File: rtl/av_ing_framer.sv
module av_ing_framer
  import av_ing_pkg::*;
#(
  parameter int PKT_LEN = 188,
  localparam int CW = $clog2(PKT_LEN + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        byte_valid,
  input  logic        pkt_sync,
  input  logic [7:0]  byte_data,
  input  logic        rx_mode,
  input  logic        abort,
  output logic        start,
  output logic        word_rdy,
  output logic        last,
  output logic [31:0] word
);

  logic          active;
  logic [CW-1:0] bcnt;
  logic [31:0]   pack;
  logic          accept;
  logic          cont;
  logic [1:0]    lane;

  assign accept   = byte_valid & ~rx_mode;
  assign start    = accept & pkt_sync;
  assign cont     = accept & ~pkt_sync & active;
  assign lane     = bcnt[1:0];
  assign last     = cont && (bcnt == CW'(PKT_LEN - 1));
  assign word_rdy = cont && ((lane == 2'd3) || last);
  assign word     = lane_insert(pack, byte_data, lane);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      bcnt   <= '0;
      pack   <= '0;
    end else if (rx_mode) begin
      active <= 1'b0;
    end else if (start) begin
      active <= ~abort;
      bcnt   <= CW'(1);
      pack   <= lane_insert(32'd0, byte_data, 2'd0);
    end else if (cont) begin
      bcnt <= bcnt + CW'(1);
      pack <= word_rdy ? 32'd0 : word;
      if (last || abort) active <= 1'b0;
    end
  end

  // R3: an open packet never holds a full packet's worth of bytes
  p_count_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (bcnt != '0) && (bcnt < CW'(PKT_LEN)));

endmodule

// File: rtl/av_ing_wrptr.sv
module av_ing_wrptr #(
  parameter int AW    = 10,
  parameter int REC_W = 48,
  localparam int PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_mode,
  input  logic          start,
  input  logic          stamp_en,
  input  logic          word_rdy,
  input  logic          last,
  input  logic [PW-1:0] rd_ptr,
  output logic          do_write,
  output logic          ovf_evt,
  output logic          done_evt,
  output logic [AW-1:0] wr_addr,
  output logic [PW-1:0] commit_ptr
);

  localparam logic [PW-1:0] DEPTH_P = PW'(1) << AW;

  function automatic logic [PW-1:0] ring_used(input logic [PW-1:0] head,
                                              input logic [PW-1:0] tail);
    return head - tail;
  endfunction

  logic [PW-1:0] wr_q, commit_q, base;
  logic          need, full;

  assign need     = (start & stamp_en) | word_rdy;
  assign base     = start ? commit_q : wr_q;
  assign full     = ring_used(base, rd_ptr) >= DEPTH_P;
  assign ovf_evt  = need & full;
  assign do_write = need & ~full;
  assign done_evt = word_rdy & last & ~full;
  assign wr_addr  = base[AW-1:0];
  assign commit_ptr = commit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q     <= '0;
      commit_q <= '0;
    end else if (rx_mode || ovf_evt) begin
      wr_q <= commit_q;
    end else if (start) begin
      wr_q <= commit_q + (stamp_en ? PW'(1) : PW'(0));
    end else if (word_rdy) begin
      wr_q <= wr_q + PW'(1);
      if (done_evt) commit_q <= wr_q + PW'(1);
    end
  end

  // R11: the speculative write position stays within one record of the commit
  p_wr_ahead_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ring_used(wr_q, commit_q) <= PW'(REC_W));

  // R9: no write is issued into a full ring
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    do_write |-> ring_used(base, rd_ptr) < DEPTH_P);

endmodule

// File: rtl/av_ingress_stamper.sv
module av_ingress_stamper
  import av_ing_pkg::*;
#(
  parameter int AW      = 10,
  parameter int PKT_LEN = 188,
  parameter int TS_W    = 25,
  localparam int REC_W  = (PKT_LEN + 3) / 4 + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            byte_valid,
  input  logic            pkt_sync,
  input  logic [7:0]      byte_data,
  input  logic            stamp_en,
  input  logic            rx_mode,
  input  logic [TS_W-1:0] cycle_time,
  input  logic [AW:0]     rd_ptr,
  output logic            wr_en,
  output logic [AW-1:0]   wr_addr,
  output logic [31:0]     wr_data,
  output logic            pkt_done,
  output logic [AW:0]     commit_ptr,
  output logic            sync_err,
  output logic            ovf_flag
);

  logic          start_w, word_rdy_w, last_w;
  logic [31:0]   word_w, stamp_w, wdata_w;
  logic          do_write_w, ovf_evt_w, done_w;
  logic [AW-1:0] addr_w;

  assign stamp_w = {{(32 - TS_W){1'b0}}, cycle_time};
  assign wdata_w = start_w ? stamp_w : word_w;

  av_ing_framer #(.PKT_LEN(PKT_LEN)) u_framer (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_valid (byte_valid),
    .pkt_sync   (pkt_sync),
    .byte_data  (byte_data),
    .rx_mode    (rx_mode),
    .abort      (ovf_evt_w),
    .start      (start_w),
    .word_rdy   (word_rdy_w),
    .last       (last_w),
    .word       (word_w)
  );

  av_ing_wrptr #(.AW(AW), .REC_W(REC_W)) u_wrptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_mode    (rx_mode),
    .start      (start_w),
    .stamp_en   (stamp_en),
    .word_rdy   (word_rdy_w),
    .last       (last_w),
    .rd_ptr     (rd_ptr),
    .do_write   (do_write_w),
    .ovf_evt    (ovf_evt_w),
    .done_evt   (done_w),
    .wr_addr    (addr_w),
    .commit_ptr (commit_ptr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      pkt_done <= 1'b0;
      sync_err <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      wr_en    <= do_write_w;
      pkt_done <= done_w;
      sync_err <= pkt_sync & ~byte_valid;
      ovf_flag <= ovf_flag | ovf_evt_w;
      if (do_write_w) begin
        wr_addr <= addr_w;
        wr_data <= wdata_w;
      end
    end
  end

  // R8: receive mode blocks the write port
  p_no_write_rx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_mode |=> !wr_en);

  // R6: a strobe without valid writes nothing
  p_err_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_sync && !byte_valid) |=> !wr_en);

  // R9: overflow flag is sticky
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);

  // R3: a done pulse always comes with a moved commit pointer and a write
  p_done_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> (wr_en && commit_ptr != $past(commit_ptr)));

endmodule

// File: tb/av_ingress_stamper_test.sv
module av_ingress_stamper_test;

  localparam int AW = 4;
  localparam int D  = 16;
  localparam int L  = 10;
  localparam int TS = 25;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid_i = 1'b0, sync_i = 1'b0, stamp_i = 1'b1, rxm_i = 1'b0;
  logic [7:0]    byte_i = 8'd0;
  logic [TS-1:0] ct_i = '0;
  int            rd_int = 0;
  logic [AW:0]   rd_ptr;
  logic          wr_en, pkt_done, sync_err, ovf_flag;
  logic [AW-1:0] wr_addr;
  logic [31:0]   wr_data;
  logic [AW:0]   commit_ptr;

  assign rd_ptr = rd_int[AW:0];

  av_ingress_stamper #(.AW(AW), .PKT_LEN(L), .TS_W(TS)) uut (
    .clk(clk), .rst_n(rst_n), .byte_valid(valid_i), .pkt_sync(sync_i),
    .byte_data(byte_i), .stamp_en(stamp_i), .rx_mode(rxm_i),
    .cycle_time(ct_i), .rd_ptr(rd_ptr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pkt_done(pkt_done), .commit_ptr(commit_ptr),
    .sync_err(sync_err), .ovf_flag(ovf_flag)
  );

  always #4 clk = ~clk;

  int    errors = 0, checks = 0, cycles = 0;
  string tag = "R1";
  bit    chk_on = 1'b0;

  // reference model state
  bit          e_wen, e_done, e_err, m_ovf, m_act;
  int          e_addr, m_commit, m_wr, m_cnt;
  logic [31:0] e_data, m_pk;

  always @(posedge clk) begin
    bit lastb, rdy;
    if (!rst_n) begin
      e_wen = 0; e_done = 0; e_err = 0; m_ovf = 0; m_act = 0;
      e_addr = 0; e_data = 0; m_commit = 0; m_wr = 0; m_cnt = 0; m_pk = 0;
    end else begin
      e_wen = 0; e_done = 0;
      e_err = sync_i && !valid_i;
      if (rxm_i) begin
        m_act = 0; m_wr = m_commit;
      end else if (valid_i && sync_i) begin
        m_cnt = 1; m_pk = {byte_i, 24'd0};
        if (stamp_i) begin
          if (m_commit - rd_int >= D) begin
            m_ovf = 1; m_act = 0; m_wr = m_commit;
          end else begin
            e_wen = 1; e_addr = m_commit % D; e_data = 32'(ct_i);
            m_wr = m_commit + 1; m_act = 1;
          end
        end else begin
          m_wr = m_commit; m_act = 1;
        end
      end else if (valid_i && m_act) begin
        m_pk = m_pk | (32'(byte_i) << (8 * (3 - m_cnt % 4)));
        lastb = (m_cnt == L - 1);
        rdy = (m_cnt % 4 == 3) || lastb;
        m_cnt++;
        if (rdy) begin
          if (m_wr - rd_int >= D) begin
            m_ovf = 1; m_act = 0; m_wr = m_commit;
          end else begin
            e_wen = 1; e_addr = m_wr % D; e_data = m_pk;
            m_wr++; m_pk = 0;
            if (lastb) begin m_commit = m_wr; e_done = 1; m_act = 0; end
          end
        end
      end
    end
  end

  task automatic cmp(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h", tag, what, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    ct_i <= ct_i + TS'(37);
    if (chk_on) begin
      cmp("wr_en", int'(wr_en), int'(e_wen));
      if (e_wen) begin
        cmp("wr_addr", int'(wr_addr), e_addr);
        cmp("wr_data", int'(wr_data), int'(e_data));
      end
      cmp("pkt_done", int'(pkt_done), int'(e_done));
      cmp("commit_ptr", int'(commit_ptr), m_commit % (2 * D));
      cmp("sync_err", int'(sync_err), int'(e_err));
      cmp("ovf_flag", int'(ovf_flag), int'(m_ovf));
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic drive(bit v, bit s, logic [7:0] d);
    @(negedge clk);
    valid_i = v; sync_i = s; byte_i = d;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, 0, 8'h00);
  endtask

  task automatic send_pkt(int n, int gap, logic [7:0] seed);
    for (int i = 0; i < n; i++) begin
      drive(1, i == 0, seed + 8'(i * 17));
      if (gap > 0 && i % 3 == 1) idle(gap);
    end
  endtask

  initial begin
    idle(3);
    chk_on = 1;
    idle(2);
    rst_n = 1;
    // R1 reset state checked during the idle cycles above and below
    idle(2);
    // R2 R4 stamped packets, contiguous and with gaps
    tag = "R4"; send_pkt(L, 0, 8'h11); idle(2);
    tag = "R2"; send_pkt(L, 2, 8'hA0); idle(2);
    rd_int = m_commit;
    // R5 R3 unstamped packet with padded tail
    tag = "R5"; stamp_i = 0; send_pkt(L, 0, 8'h3C); idle(1);
    tag = "R3"; send_pkt(L, 1, 8'hC3); idle(1);
    stamp_i = 1;
    rd_int = m_commit;
    // R7 bytes before sync and after completion
    tag = "R7";
    drive(1, 0, 8'h55); drive(1, 0, 8'h66);
    send_pkt(L, 0, 8'h01);
    drive(1, 0, 8'h77); drive(1, 0, 8'h88); idle(1);
    // R6 sync without valid, mid-packet and idle
    tag = "R6";
    drive(0, 1, 8'hEE);
    drive(1, 1, 8'h20); drive(1, 0, 8'h21); drive(0, 1, 8'h99);
    for (int i = 2; i < L; i++) drive(1, 0, 8'(8'h20 + i));
    idle(1);
    rd_int = m_commit;
    // R10 early sync drops the open packet
    tag = "R10";
    send_pkt(6, 0, 8'h40); send_pkt(L, 0, 8'h50); idle(1);
    // R8 receive mode mid-packet
    tag = "R8";
    send_pkt(5, 0, 8'h60);
    rxm_i = 1; drive(1, 0, 8'h65); drive(1, 1, 8'h66); drive(1, 0, 8'h67);
    rxm_i = 0; drive(1, 0, 8'h68);
    send_pkt(L, 0, 8'h70); idle(1);
    rd_int = m_commit;
    // R9 fill the ring, then overflow at the stamp and mid-packet
    tag = "R9";
    for (int k = 0; k < 5; k++) begin send_pkt(L, 0, 8'(8'h80 + k)); idle(1); end
    rd_int = m_commit - 14;
    send_pkt(L, 0, 8'h90); idle(2);
    // R11 wrap with the ring freed
    tag = "R11";
    rd_int = m_commit;
    stamp_i = 0;
    for (int k = 0; k < 8; k++) begin
      send_pkt(L, k % 2, 8'(8'hB0 + k)); idle(1);
      rd_int = m_commit;
    end
    stamp_i = 1;
    for (int k = 0; k < 3; k++) begin
      send_pkt(L, 0, 8'(8'hD0 + k)); idle(1);
      rd_int = m_commit;
    end
    idle(3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule